// File: doc/BRIEF.md
# Drawing Engine Control and Status Register Block

This block is the register front end of a 2D drawing engine. Software reaches it over a simple single-cycle bus. Each access carries an address, a write enable, a read enable and a 32-bit write word. Read data is combinational and is valid in the same cycle as the read enable.

The block drives two signals into the drawing core. One is a software-reset level. The other is a start pulse, one clock wide. It also accepts a trap pulse from the core, which marks the end of a drawing run. Between a start and its trap the engine is busy, and any further start request is refused and recorded.

After a hardware reset the engine sits in software reset. While that reset bit is set, only the control word accepts writes, and the generic parameter words are held at zero. Software clears the bit before the first drawing run.

Top module: `draw_ctrl_regs`

## Requirements
- R1: The control word is at offset 0x000. Bit 31 is the software-reset bit and can be read and written. Bit 0 is the start request and always reads 0. Bits 30..1 read 0 and ignore writes.
- R2: After hardware reset the control word reads 0x80000000 and the status word reads 0x80000000. Both parameter words read 0, core_srst is 1 and core_start is 0.
- R3: While the software-reset bit is 1, writes to any address other than 0x000 are discarded. The parameter words are held at 0, no start pulse is issued, and core_srst equals the bit.
- R4: A legal start is a control write with bit 0 = 1 and bit 31 = 0, made while the reset bit is 0 and the engine is not busy. It drives core_start high for exactly the one cycle after the write, and busy is set from that same cycle.
- R5: The status word is at offset 0x004. Bit 0 is busy. Bit 1 is the illegal-start flag. Bit 31 is 1 while the reset bit is 1 or no legal start has happened since the last reset. All other bits read 0. Writes to this word have no effect.
- R6: An illegal start is a control write with bit 0 = 1 that is not legal under R4. It produces no start pulse and sets status bit 1.
- R7: The illegal-start flag stays set until a control write with bit 31 = 1 clears it. A write that is itself an illegal start sets the flag instead. A control write with bit 31 = 1 also clears busy and the started state.
- R8: Busy clears in the cycle after the cycle in which core_trap is high. core_trap while idle has no effect.
- R9: Two 32-bit parameter words at offsets 0x008 and 0x00C can be read and written, and return the last value written.
- R10: Reads of unmapped or unaligned offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| bus_addr | input | ADDR_W (12) | Byte offset of the access |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when bus_re is low |
| core_srst | output | 1 | Software-reset level to the drawing core |
| core_start | output | 1 | One-cycle start pulse to the drawing core |
| core_trap | input | 1 | Trap-executed pulse from the drawing core |

## Verification
The checker asserts on every cycle that the start pulse lasts one cycle and always coincides with busy. It also asserts that no pulse follows a refused request or appears during software reset, that a trap ends busy on the next cycle, that the error flag never drops without a control write, and that the parameter words stay zero while reset is held. The read-back layout of both words, the discarding of writes during reset, and the status-word and unmapped-address behaviour can only be shown by the bench's directed sequences. The same holds for the ordering of release, start, refused start, trap and re-reset.

// File: rtl/draw_regs_pkg.sv
package draw_regs_pkg;

  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_CTRL   = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_PARAM  = 2'd3
  } reg_sel_t;

  typedef struct packed {
    logic srst;
    logic started;
    logic err;
    logic busy;
  } run_state_t;

  // Status word: bit31 idle/reset indicator, bit1 error, bit0 busy.
  function automatic logic [DATA_W-1:0] status_word(input run_state_t s);
    return {s.srst | ~s.started, {(DATA_W-3){1'b0}}, s.err, s.busy};
  endfunction

  // Control word read-back: only the reset bit is visible.
  function automatic logic [DATA_W-1:0] ctrl_word(input logic srst);
    return {srst, {(DATA_W-1){1'b0}}};
  endfunction

endpackage

// File: rtl/draw_reg_decode.sv
module draw_reg_decode
  import draw_regs_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned PARAM_N = 2,
  localparam int unsigned IDX_W  = (PARAM_N > 1) ? $clog2(PARAM_N) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel,
  output logic [IDX_W-1:0]  param_idx
);

  localparam int unsigned WORD_W     = ADDR_W - 2;
  localparam int unsigned PARAM_BASE = 2;

  logic [WORD_W-1:0] word;
  logic              aligned;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    sel       = SEL_NONE;
    param_idx = '0;
    if (aligned) begin
      if (word == WORD_W'(0)) begin
        sel = SEL_CTRL;
      end else if (word == WORD_W'(1)) begin
        sel = SEL_STATUS;
      end else if ((word >= WORD_W'(PARAM_BASE)) &&
                   (word < WORD_W'(PARAM_BASE + PARAM_N))) begin
        sel       = SEL_PARAM;
        param_idx = IDX_W'(word - WORD_W'(PARAM_BASE));
      end
    end
  end

endmodule

// File: rtl/draw_run_ctrl.sv
module draw_run_ctrl
  import draw_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic       wdata_srst,
  input  logic       wdata_start,
  input  logic       trap_in,
  output run_state_t state,
  output logic       start_pulse,
  output logic       legal_start,
  output logic       illegal_start
);

  logic start_req;
  logic srst_write;

  assign start_req     = ctrl_wr & wdata_start;
  assign srst_write    = ctrl_wr & wdata_srst;
  assign legal_start   = start_req & ~state.srst & ~state.busy & ~wdata_srst;
  assign illegal_start = start_req & ~legal_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state.srst    <= 1'b1;
      state.started <= 1'b0;
      state.err     <= 1'b0;
      state.busy    <= 1'b0;
      start_pulse   <= 1'b0;
    end else begin
      start_pulse <= legal_start;

      if (ctrl_wr) begin
        state.srst <= wdata_srst;
      end

      if (illegal_start) begin
        state.err <= 1'b1;
      end else if (srst_write) begin
        state.err <= 1'b0;
      end

      if (state.srst || srst_write) begin
        state.busy    <= 1'b0;
        state.started <= 1'b0;
      end else if (legal_start) begin
        state.busy    <= 1'b1;
        state.started <= 1'b1;
      end else if (trap_in && state.busy) begin
        state.busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/draw_param_bank.sv
module draw_param_bank
  import draw_regs_pkg::*;
#(
  parameter int unsigned PARAM_N = 2,
  localparam int unsigned IDX_W  = (PARAM_N > 1) ? $clog2(PARAM_N) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clear,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [DATA_W-1:0]              wdata,
  output logic [PARAM_N-1:0][DATA_W-1:0] q
);

  for (genvar g = 0; g < PARAM_N; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[g] <= '0;
      end else if (clear) begin
        q[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        q[g] <= wdata;
      end
    end
  end

endmodule

// File: rtl/draw_ctrl_regs.sv
module draw_ctrl_regs
  import draw_regs_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned PARAM_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              core_srst,
  output logic              core_start,
  input  logic              core_trap
);

  localparam int unsigned IDX_W = (PARAM_N > 1) ? $clog2(PARAM_N) : 1;

  reg_sel_t                      sel;
  logic [IDX_W-1:0]              param_idx;
  run_state_t                    run_state;
  logic                          ctrl_wr;
  logic                          param_wr;
  logic                          legal_start;
  logic                          illegal_start;
  logic [PARAM_N-1:0][DATA_W-1:0] params;
  logic                          params_zero;
  logic                          busy;
  logic                          err;

  draw_reg_decode #(.ADDR_W(ADDR_W), .PARAM_N(PARAM_N)) u_decode (
    .addr      (bus_addr),
    .sel       (sel),
    .param_idx (param_idx)
  );

  // Only the control word is writable while the reset bit is set.
  assign ctrl_wr  = bus_we & (sel == SEL_CTRL);
  assign param_wr = bus_we & (sel == SEL_PARAM) & ~run_state.srst;

  draw_run_ctrl u_run (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_wr       (ctrl_wr),
    .wdata_srst    (bus_wdata[31]),
    .wdata_start   (bus_wdata[0]),
    .trap_in       (core_trap),
    .state         (run_state),
    .start_pulse   (core_start),
    .legal_start   (legal_start),
    .illegal_start (illegal_start)
  );

  draw_param_bank #(.PARAM_N(PARAM_N)) u_params (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (run_state.srst),
    .wr_en  (param_wr),
    .wr_idx (param_idx),
    .wdata  (bus_wdata),
    .q      (params)
  );

  assign core_srst   = run_state.srst;
  assign busy        = run_state.busy;
  assign err         = run_state.err;
  assign params_zero = (params == '0);

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      unique case (sel)
        SEL_CTRL:   bus_rdata = ctrl_word(run_state.srst);
        SEL_STATUS: bus_rdata = status_word(run_state);
        SEL_PARAM:  bus_rdata = params[param_idx];
        default:    bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/draw_ctrl_regs_chk.sv
module draw_ctrl_regs_chk (
  input logic clk,
  input logic rst_n,
  input logic core_srst,
  input logic core_start,
  input logic core_trap,
  input logic busy,
  input logic err,
  input logic ctrl_wr,
  input logic illegal_start,
  input logic params_zero
);

  a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);

  a_r4_start_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> busy);

  a_r6_refused_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_start |=> !core_start);

  a_r8_trap_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && core_trap) |=> !busy);

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !ctrl_wr) |=> err);

  a_r3_params_held: assert property (@(posedge clk) disable iff (!rst_n)
    core_srst |=> params_zero);

  a_r3_srst_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    core_srst |-> !core_start);

endmodule

bind draw_ctrl_regs draw_ctrl_regs_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .core_srst     (core_srst),
  .core_start    (core_start),
  .core_trap     (core_trap),
  .busy          (busy),
  .err           (err),
  .ctrl_wr       (ctrl_wr),
  .illegal_start (illegal_start),
  .params_zero   (params_zero)
);

// File: tb/test_draw_ctrl_regs.sv
`timescale 1ns/1ps
module test_draw_ctrl_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        core_srst;
  logic        core_start;
  logic        core_trap = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  draw_ctrl_regs i_draw_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_srst(core_srst), .core_start(core_start), .core_trap(core_trap)
  );

  function automatic logic [31:0] expect_status(bit rst_bit, bit ran, bit bad, bit run);
    logic [31:0] v = 32'h0;
    if (rst_bit || !ran) v = 32'h8000_0000;
    if (bad) v = v + 32'd2;
    if (run) v = v + 32'd1;
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic trap_pulse();
    @(negedge clk);
    core_trap = 1'b1;
    @(negedge clk);
    core_trap = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R2 srst out", 32'(core_srst), 32'd1);
    check("R2 start out", 32'(core_start), 32'd0);
    rd(12'h000, v); check("R2 ctrl", v, 32'h8000_0000);
    rd(12'h004, v); check("R2 status", v, 32'h8000_0000);
    rd(12'h008, v); check("R2 param0", v, 32'h0);
    rd(12'h00C, v); check("R2 param1", v, 32'h0);
  endtask

  task automatic t_lockout();
    logic [31:0] v;
    wr(12'h008, 32'hDEAD_BEEF);
    rd(12'h008, v); check("R3 param locked", v, 32'h0);
    wr(12'h00C, 32'h1234_5678);
    rd(12'h00C, v); check("R3 param1 locked", v, 32'h0);
    wr(12'h000, 32'h8000_0001);
    check("R6 no pulse in srst", 32'(core_start), 32'd0);
    rd(12'h004, v); check("R6 err set in srst", v, expect_status(1, 0, 1, 0));
    check("R3 srst held", 32'(core_srst), 32'd1);
  endtask

  task automatic t_release_and_layout();
    logic [31:0] v;
    wr(12'h000, 32'h0000_0000);
    check("R3 srst released", 32'(core_srst), 32'd0);
    rd(12'h004, v); check("R7 err survives release", v, expect_status(0, 0, 1, 0));
    wr(12'h000, 32'h7FFF_FFFE);
    check("R1 reserved no start", 32'(core_start), 32'd0);
    rd(12'h000, v); check("R1 reserved read 0", v, 32'h0);
    wr(12'h008, 32'hA5A5_5A5A);
    wr(12'h00C, 32'hFFFF_0001);
    rd(12'h008, v); check("R9 param0 rw", v, 32'hA5A5_5A5A);
    rd(12'h00C, v); check("R9 param1 rw", v, 32'hFFFF_0001);
  endtask

  task automatic t_run();
    logic [31:0] v;
    wr(12'h000, 32'h0000_0001);
    check("R4 start pulse high", 32'(core_start), 32'd1);
    @(negedge clk);
    check("R4 start pulse one cycle", 32'(core_start), 32'd0);
    rd(12'h000, v); check("R1 start self-clears", v, 32'h0);
    rd(12'h004, v); check("R5 busy shown", v, expect_status(0, 1, 1, 1));
    wr(12'h000, 32'h0000_0001);
    check("R6 no pulse when busy", 32'(core_start), 32'd0);
    trap_pulse();
    rd(12'h004, v); check("R8 busy ends after trap", v, expect_status(0, 1, 1, 0));
    trap_pulse();
    rd(12'h004, v); check("R8 idle trap no effect", v, expect_status(0, 1, 1, 0));
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h004, v); check("R5 status write ignored", v, expect_status(0, 1, 1, 0));
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(12'h010, 32'hFFFF_FFFF);
    wr(12'h009, 32'h0BAD_0BAD);
    rd(12'h010, v); check("R10 unmapped read 0", v, 32'h0);
    rd(12'h00A, v); check("R10 unaligned read 0", v, 32'h0);
    rd(12'h008, v); check("R10 param0 untouched", v, 32'hA5A5_5A5A);
    rd(12'h000, v); check("R10 ctrl untouched", v, 32'h0);
  endtask

  task automatic t_rereset();
    logic [31:0] v;
    wr(12'h000, 32'h0000_0001);
    check("R4 second start pulse", 32'(core_start), 32'd1);
    wr(12'h000, 32'h8000_0000);
    check("R3 srst reasserted", 32'(core_srst), 32'd1);
    rd(12'h004, v); check("R7 srst clears err busy", v, 32'h8000_0000);
    rd(12'h008, v); check("R3 param0 cleared", v, 32'h0);
    rd(12'h00C, v); check("R3 param1 cleared", v, 32'h0);
    wr(12'h000, 32'h0);
    wr(12'h000, 32'h1);
    check("R4 start after re-release", 32'(core_start), 32'd1);
    rd(12'h004, v); check("R5 clean busy status", v, expect_status(0, 1, 0, 1));
    trap_pulse();
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_lockout();
    t_release_and_layout();
    t_run();
    t_unmapped();
    t_rereset();
    finish_run();
  end

endmodule